// File: doc/BRIEF.md
# Banked Interrupt Distributor Register File

This block is the per-interrupt state store of a small interrupt controller. Software reaches it through a single 32-bit register port that carries a word address and the index of the CPU making the access. For every interrupt ID the block keeps a group bit, an enable bit, a pending bit, an active bit, an edge/level trigger flag, an 8-bit priority and, for shared interrupts, an 8-bit CPU target mask. IDs 0 to 31 are private: each CPU has its own copy, and an access reaches the copy of the CPU named on the port. IDs 32 and above have one copy that all CPUs share. The first 16 private IDs are software-generated interrupts. For each of them and each CPU the block also holds a byte of source-pending bits.

Enable, pending and active each have two views, one to set bits and one to clear them. Both views read back the same state. The hardware lines arrive as one flat vector, and the block splits it into shared and private interrupts. A pending bit comes from an input line in one of two ways. An edge-configured interrupt latches pending on a rising edge. A level-configured interrupt shows pending for as long as its line is high. Read data is registered and appears one cycle after the read request.

Top module: `irq_dist_regs`

## Requirements
- R1: After reset every stored bit, byte and mask is zero, the control bit is zero and the read data is zero.
- R2: Word 0x000/4 holds a control bit in bit 0 that can be written and read back, with other bits reading zero. Word 0x004/4 is read-only and returns (NUM_IRQ/32 − 1) in bits [4:0] and (NUM_CPU − 1) in bits [7:5].
- R3: Enable (set 0x100, clear 0x180), pending (set 0x200, clear 0x280) and active (set 0x300, clear 0x380) hold one bit per ID, 32 IDs per word, ID = 32·word + bit. A 1 written to a set view sets the bit, a 1 written to a clear view clears it, and a 0 changes nothing. Both views read the current state.
- R4: Group bits at 0x080 are written directly, one bit per ID, 32 IDs per word.
- R5: For IDs below 32, every access reaches only the copy of the CPU given on acc_cpu. IDs 32 and above are seen identically from every CPU.
- R6: Priorities at 0x400 are 8 bits per ID, 4 IDs per word, with the lowest ID in bits [7:0]. Words 0 to 7 are banked per CPU and the rest are shared.
- R7: Target masks at 0x800 are 8 bits per ID, 4 IDs per word. Shared IDs are read/write. For a private ID, writes are ignored and each byte reads as the one-hot bit of the accessing CPU.
- R8: Trigger fields at 0xC00 are 2 bits per ID, 16 IDs per word. Field bit 1 = 1 means edge and 0 means level. Field bit 0 ignores writes and reads 0. Words 0 and 1 are banked per CPU.
- R9: Flat input index i < NUM_IRQ−32 drives shared ID i+32. A higher index with j = i−(NUM_IRQ−32) drives private ID j mod 32 of CPU j/32.
- R10: An edge-configured ID latches pending on a rising edge of its line. A level-configured ID reads pending while its line is high, even after a clear, and reads not pending once the line is low unless software set it.
- R11: Software-interrupt source bytes are one byte per SGI (0..15) per CPU, 4 per word. A 1 written at 0xF20 sets source bits and a 1 written at 0xF10 clears them. Both views read the state of the accessing CPU.
- R12: Words past the configured interrupt count in the bit, priority, target and trigger regions read zero and ignore writes.
- R13: acc_rdata changes only on the clock edge that takes a read request. It then holds the value read until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_en | input | 1 | Access request this cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_cpu | input | CW | Index of the accessing CPU (selects the private bank) |
| acc_word | input | 10 | Word address (byte offset / 4) |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Registered read data, valid the cycle after a read |
| irq_lines | input | NUM_CPU·32+NUM_IRQ−32 | Flat hardware interrupt line vector |

## Verification
The assertions assume that acc_cpu always names an existing CPU, since the one-hot target read and the banked indexing depend on it. They also assume that acc_wr has meaning only while acc_en is high. The bench stays within these limits. It uses CPU indices 0 and 1 only, issues one access at a time, always returns acc_en low between accesses, and changes irq_lines only on falling edges. That keeps every edge-detection case a clean single transition.

// File: rtl/dist_pkg.sv
package dist_pkg;
  // Write operation applied to one word of a state bank
  typedef enum logic [1:0] {
    WM_NONE   = 2'd0,
    WM_DIRECT = 2'd1,
    WM_SET    = 2'd2,
    WM_CLEAR  = 2'd3
  } wmode_e;

  localparam int PRIV_IDS   = 32;
  localparam int PRIO_PRIV_W = PRIV_IDS / 4;  // banked priority words
endpackage

// File: rtl/dist_line_map.sv
// Reorders the flat line vector into slot order: private slots first
// (cpu*32 + id), shared slots after (NUM_CPU*32 + id - 32).
module dist_line_map #(
  parameter int NUM_IRQ = 64,
  parameter int NUM_CPU = 2,
  parameter int SLOTS   = NUM_CPU * 32 + NUM_IRQ - 32
) (
  input  logic [SLOTS-1:0] lines_in,
  output logic [SLOTS-1:0] slot_lines
);
  localparam int SHARED = NUM_IRQ - 32;
  localparam int PRIV   = NUM_CPU * 32;

  for (genvar k = 0; k < PRIV; k++) begin : g_priv
    assign slot_lines[k] = lines_in[SHARED + k];
  end
  for (genvar s = 0; s < SHARED; s++) begin : g_shared
    assign slot_lines[PRIV + s] = lines_in[s];
  end
endmodule

// File: rtl/dist_bit_bank.sv
// One bit of state per slot, organised as 32-bit words.
module dist_bit_bank
  import dist_pkg::*;
#(
  parameter int WORDS = 3,
  parameter int IW    = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  wmode_e              mode,
  input  logic [IW-1:0]       widx,
  input  logic [31:0]         wdata,
  input  logic [31:0]         wen,
  input  logic [WORDS*32-1:0] hw_set,
  output logic [WORDS*32-1:0] state
);
  logic [WORDS*32-1:0] nxt;
  logic [31:0]         cur;

  always_comb begin
    nxt = state | hw_set;
    cur = nxt[widx*32 +: 32];
    case (mode)
      WM_DIRECT: nxt[widx*32 +: 32] = (cur & ~wen) | (wdata & wen);
      WM_SET:    nxt[widx*32 +: 32] = cur | wdata;
      WM_CLEAR:  nxt[widx*32 +: 32] = cur & ~wdata;
      default:   ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= '0;
    else     state <= nxt;
  end
endmodule

// File: rtl/dist_byte_bank.sv
// Word array holding packed byte fields (priorities, targets, sources).
module dist_byte_bank
  import dist_pkg::*;
#(
  parameter int WORDS = 8,
  parameter int IW    = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  wmode_e        mode,
  input  logic [IW-1:0] idx,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata
);
  logic [31:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '0;
    end else begin
      case (mode)
        WM_DIRECT: mem[idx] <= wdata;
        WM_SET:    mem[idx] <= mem[idx] | wdata;
        WM_CLEAR:  mem[idx] <= mem[idx] & ~wdata;
        default:   ;
      endcase
    end
  end

  assign rdata = mem[idx];
endmodule

// File: rtl/irq_dist_regs.sv
module irq_dist_regs
  import dist_pkg::*;
#(
  parameter int NUM_IRQ = 64,
  parameter int NUM_CPU = 2,
  parameter int CW      = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
  parameter int SLOTS   = NUM_CPU * 32 + NUM_IRQ - 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acc_en,
  input  logic             acc_wr,
  input  logic [CW-1:0]    acc_cpu,
  input  logic [9:0]       acc_word,
  input  logic [31:0]      acc_wdata,
  output logic [31:0]      acc_rdata,
  input  logic [SLOTS-1:0] irq_lines
);
  localparam int BWORDS = SLOTS / 32;
  localparam int PWORDS = NUM_CPU * PRIO_PRIV_W + (NUM_IRQ - 32) / 4;
  localparam int TWORDS = (NUM_IRQ - 32) / 4;
  localparam int SWORDS = NUM_CPU * 4;
  localparam int BIW    = (BWORDS > 1) ? $clog2(BWORDS) : 1;
  localparam int PIW    = (PWORDS > 1) ? $clog2(PWORDS) : 1;
  localparam int TIW    = (TWORDS > 1) ? $clog2(TWORDS) : 1;
  localparam int SIW    = (SWORDS > 1) ? $clog2(SWORDS) : 1;
  localparam logic [31:0] TYPE_VAL =
    32'(NUM_IRQ / 32 - 1) | (32'(NUM_CPU - 1) << 5);

  // ---------------- address decode ----------------
  logic       wr_go, rd_go;
  logic [2:0] bkind;
  logic [4:0] bw;
  logic [7:0] pw;
  logic [5:0] tw;
  logic       bit_hit, prio_hit, tgt_hit, tgt_priv, trg_hit;
  logic       sgi_clr_hit, sgi_set_hit;
  logic [BIW-1:0] bit_slot, trg_slot;
  logic [PIW-1:0] prio_slot;
  logic [TIW-1:0] tgt_slot;
  logic [SIW-1:0] sgi_slot;

  assign wr_go = acc_en & acc_wr;
  assign rd_go = acc_en & ~acc_wr;
  assign bkind = acc_word[7:5];
  assign bw    = acc_word[4:0];
  assign pw    = acc_word[7:0];
  assign tw    = acc_word[5:0];

  assign bit_hit  = (acc_word[9:8] == 2'b00) && (bkind != 3'd0) &&
                    (32'(bw) < NUM_IRQ / 32);
  assign prio_hit = (acc_word[9:8] == 2'b01) && (32'(pw) < NUM_IRQ / 4);
  assign tgt_hit  = (acc_word[9:8] == 2'b10) && (32'(pw) < NUM_IRQ / 4);
  assign tgt_priv = (32'(pw) < PRIO_PRIV_W);
  assign trg_hit  = (acc_word[9:6] == 4'hC) && (32'(tw) < NUM_IRQ / 16);
  assign sgi_clr_hit = (acc_word[9:2] == 8'hF1);
  assign sgi_set_hit = (acc_word[9:2] == 8'hF2);

  assign bit_slot  = (bw == 5'd0) ? BIW'(acc_cpu)
                                  : BIW'(32'(NUM_CPU) + 32'(bw) - 32'd1);
  assign trg_slot  = (tw[5:1] == 5'd0) ? BIW'(acc_cpu)
                                       : BIW'(32'(NUM_CPU) + 32'(tw[5:1]) - 32'd1);
  assign prio_slot = tgt_priv ? PIW'(32'(acc_cpu) * 32'(PRIO_PRIV_W) + 32'(pw))
                              : PIW'(32'(NUM_CPU * PRIO_PRIV_W) + 32'(pw) - 32'(PRIO_PRIV_W));
  assign tgt_slot  = TIW'(32'(pw) - 32'(PRIO_PRIV_W));
  assign sgi_slot  = SIW'(32'(acc_cpu) * 32'd4 + 32'(acc_word[1:0]));

  // ---------------- write modes ----------------
  wmode_e m_grp, m_en, m_pend, m_act, m_trg, m_prio, m_tgt, m_sgi;

  always_comb begin
    m_grp = WM_NONE; m_en = WM_NONE; m_pend = WM_NONE; m_act = WM_NONE;
    m_trg = WM_NONE; m_prio = WM_NONE; m_tgt = WM_NONE; m_sgi = WM_NONE;
    if (wr_go && bit_hit) begin
      case (bkind)
        3'd1:    m_grp  = WM_DIRECT;
        3'd2:    m_en   = WM_SET;
        3'd3:    m_en   = WM_CLEAR;
        3'd4:    m_pend = WM_SET;
        3'd5:    m_pend = WM_CLEAR;
        3'd6:    m_act  = WM_SET;
        3'd7:    m_act  = WM_CLEAR;
        default: ;
      endcase
    end
    if (wr_go && trg_hit)              m_trg  = WM_DIRECT;
    if (wr_go && prio_hit)             m_prio = WM_DIRECT;
    if (wr_go && tgt_hit && !tgt_priv) m_tgt  = WM_DIRECT;
    if (wr_go && sgi_set_hit)          m_sgi  = WM_SET;
    if (wr_go && sgi_clr_hit)          m_sgi  = WM_CLEAR;
  end

  // trigger: keep only the edge bit of each 2-bit field
  logic [15:0] edge_w;
  logic [31:0] trg_wdata, trg_wen;
  always_comb begin
    for (int k = 0; k < 16; k++) edge_w[k] = acc_wdata[2*k+1];
  end
  assign trg_wdata = tw[0] ? {edge_w, 16'h0} : {16'h0, edge_w};
  assign trg_wen   = tw[0] ? 32'hFFFF_0000 : 32'h0000_FFFF;

  // ---------------- line mapping and pending ----------------
  logic [SLOTS-1:0] slot_lines, prev_lines, edge_set, pend_view;
  logic [SLOTS-1:0] grp_st, en_st, pend_st, act_st, trg_st;

  dist_line_map #(.NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU), .SLOTS(SLOTS)) map_i (
    .lines_in(irq_lines), .slot_lines(slot_lines));

  always_ff @(posedge clk) begin
    if (rst) prev_lines <= '0;
    else     prev_lines <= slot_lines;
  end
  assign edge_set  = slot_lines & ~prev_lines & trg_st;
  assign pend_view = pend_st | (slot_lines & ~trg_st);

  // ---------------- state banks ----------------
  dist_bit_bank #(.WORDS(BWORDS), .IW(BIW)) grp_i (
    .clk, .rst, .mode(m_grp), .widx(bit_slot), .wdata(acc_wdata),
    .wen('1), .hw_set('0), .state(grp_st));
  dist_bit_bank #(.WORDS(BWORDS), .IW(BIW)) en_i (
    .clk, .rst, .mode(m_en), .widx(bit_slot), .wdata(acc_wdata),
    .wen('1), .hw_set('0), .state(en_st));
  dist_bit_bank #(.WORDS(BWORDS), .IW(BIW)) pend_i (
    .clk, .rst, .mode(m_pend), .widx(bit_slot), .wdata(acc_wdata),
    .wen('1), .hw_set(edge_set), .state(pend_st));
  dist_bit_bank #(.WORDS(BWORDS), .IW(BIW)) act_i (
    .clk, .rst, .mode(m_act), .widx(bit_slot), .wdata(acc_wdata),
    .wen('1), .hw_set('0), .state(act_st));
  dist_bit_bank #(.WORDS(BWORDS), .IW(BIW)) trg_i (
    .clk, .rst, .mode(m_trg), .widx(trg_slot), .wdata(trg_wdata),
    .wen(trg_wen), .hw_set('0), .state(trg_st));

  logic [31:0] prio_rd, tgt_rd, sgi_rd;
  dist_byte_bank #(.WORDS(PWORDS), .IW(PIW)) prio_i (
    .clk, .rst, .mode(m_prio), .idx(prio_slot), .wdata(acc_wdata), .rdata(prio_rd));
  dist_byte_bank #(.WORDS(TWORDS), .IW(TIW)) tgt_i (
    .clk, .rst, .mode(m_tgt), .idx(tgt_slot), .wdata(acc_wdata), .rdata(tgt_rd));
  dist_byte_bank #(.WORDS(SWORDS), .IW(SIW)) sgi_i (
    .clk, .rst, .mode(m_sgi), .idx(sgi_slot), .wdata(acc_wdata), .rdata(sgi_rd));

  logic ctrl_en;
  always_ff @(posedge clk) begin
    if (rst)                              ctrl_en <= 1'b0;
    else if (wr_go && acc_word == 10'd0)  ctrl_en <= acc_wdata[0];
  end

  // ---------------- read path ----------------
  logic [31:0] rd_nxt, trg_word;
  logic [15:0] trg_half;
  assign trg_word = trg_st[trg_slot*32 +: 32];
  assign trg_half = tw[0] ? trg_word[31:16] : trg_word[15:0];

  always_comb begin
    rd_nxt = '0;
    if (acc_word == 10'd0)       rd_nxt = {31'd0, ctrl_en};
    else if (acc_word == 10'd1)  rd_nxt = TYPE_VAL;
    else if (bit_hit) begin
      case (bkind)
        3'd1:       rd_nxt = grp_st[bit_slot*32 +: 32];
        3'd2, 3'd3: rd_nxt = en_st[bit_slot*32 +: 32];
        3'd4, 3'd5: rd_nxt = pend_view[bit_slot*32 +: 32];
        default:    rd_nxt = act_st[bit_slot*32 +: 32];
      endcase
    end
    else if (prio_hit) rd_nxt = prio_rd;
    else if (tgt_hit)  rd_nxt = tgt_priv ? {4{8'(32'd1 << acc_cpu)}} : tgt_rd;
    else if (trg_hit) begin
      for (int k = 0; k < 16; k++) rd_nxt[2*k+1] = trg_half[k];
    end
    else if (sgi_clr_hit || sgi_set_hit) rd_nxt = sgi_rd;
  end

  always_ff @(posedge clk) begin
    if (rst)        acc_rdata <= '0;
    else if (rd_go) acc_rdata <= rd_nxt;
  end
endmodule

// File: rtl/irq_dist_regs_chk.sv
module irq_dist_regs_chk #(
  parameter int NUM_IRQ = 64,
  parameter int NUM_CPU = 2,
  parameter int CW      = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
  parameter int SLOTS   = NUM_CPU * 32 + NUM_IRQ - 32
) (
  input logic          clk,
  input logic          rst,
  input logic          acc_en,
  input logic          acc_wr,
  input logic [CW-1:0] acc_cpu,
  input logic [9:0]    acc_word,
  input logic [31:0]   acc_rdata
);
  localparam logic [31:0] TYPE_EXP =
    32'(NUM_IRQ / 32 - 1) | (32'(NUM_CPU - 1) << 5);

  // R2
  type_value_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_en && !acc_wr && acc_word == 10'd1) |=> acc_rdata == TYPE_EXP);

  // R7
  priv_target_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_en && !acc_wr && acc_word[9:8] == 2'b10 && acc_word[7:0] < 8'd8)
    |=> acc_rdata == {4{8'(32'd1 << $past(acc_cpu))}});

  // R8
  trig_low_bit_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_en && !acc_wr && acc_word[9:6] == 4'hC)
    |=> (acc_rdata & 32'h5555_5555) == 32'd0);

  // R12
  prio_range_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_en && !acc_wr && acc_word[9:8] == 2'b01 &&
     32'(acc_word[7:0]) >= NUM_IRQ / 4) |=> acc_rdata == 32'd0);

  // R13
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(acc_en && !acc_wr) |=> $stable(acc_rdata));
endmodule

bind irq_dist_regs irq_dist_regs_chk #(
  .NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU), .CW(CW), .SLOTS(SLOTS)
) chk_i (.*);

// File: tb/irq_dist_regs_tb.sv
module irq_dist_regs_tb_top;
  localparam int NUM_IRQ = 64;
  localparam int NUM_CPU = 2;
  localparam int CW      = 1;
  localparam int SLOTS   = NUM_CPU * 32 + NUM_IRQ - 32;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             acc_en = 1'b0;
  logic             acc_wr = 1'b0;
  logic [CW-1:0]    acc_cpu = '0;
  logic [9:0]       acc_word = '0;
  logic [31:0]      acc_wdata = '0;
  logic [31:0]      acc_rdata;
  logic [SLOTS-1:0] irq_lines = '0;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  irq_dist_regs #(.NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU)) dut_i (
    .clk, .rst, .acc_en, .acc_wr, .acc_cpu, .acc_word,
    .acc_wdata, .acc_rdata, .irq_lines);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_wr(input int c, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    acc_en = 1'b1; acc_wr = 1'b1; acc_cpu = CW'(c);
    acc_word = a[11:2]; acc_wdata = d;
    @(negedge clk);
    acc_en = 1'b0; acc_wr = 1'b0;
  endtask

  task automatic rd_chk(input string req, input int c, input logic [11:0] a,
                        input logic [31:0] exp);
    @(negedge clk);
    acc_en = 1'b1; acc_wr = 1'b0; acc_cpu = CW'(c); acc_word = a[11:2];
    @(negedge clk);
    acc_en = 1'b0;
    check(req, acc_rdata, exp);
  endtask

  function automatic logic [31:0] pval(int c, int p);
    return 32'(p) * 32'h0101_0101 + 32'(c) * 32'h8040_2010 + 32'h0003_0201;
  endfunction

  function automatic logic [31:0] tval(int c, int p);
    return 32'(p) * 32'h0011_0305 + 32'(c) * 32'h4000_0080 + 32'h0100_0000;
  endfunction

  initial begin
    #1_500_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [11:0] sb [3];
    logic [11:0] cb [3];
    logic [31:0] a_pat;
    sb[0] = 12'h100; cb[0] = 12'h180;
    sb[1] = 12'h200; cb[1] = 12'h280;
    sb[2] = 12'h300; cb[2] = 12'h380;
    a_pat = 32'hA5A5_0F0F;

    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1: reset values
    check("R1 rdata after reset", acc_rdata, 32'd0);
    for (int c = 0; c < NUM_CPU; c++) begin
      for (int r = 1; r < 8; r++) begin
        for (int w = 0; w < 2; w++)
          rd_chk("R1 bit regs reset", c, 12'(r * 128 + w * 4), 32'd0);
      end
      rd_chk("R1 priority reset", c, 12'h400, 32'd0);
      rd_chk("R1 shared target reset", c, 12'h820, 32'd0);
      rd_chk("R1 sgi reset", c, 12'hF20, 32'd0);
    end
    rd_chk("R1 control reset", 0, 12'h000, 32'd0);

    // R2: type and control
    rd_chk("R2 type", 0, 12'h004, 32'h0000_0021);
    rd_chk("R2 type cpu1", 1, 12'h004, 32'h0000_0021);
    do_wr(0, 12'h004, 32'hFFFF_FFFF);
    rd_chk("R2 type read-only", 0, 12'h004, 32'h0000_0021);
    do_wr(0, 12'h000, 32'hFFFF_FFFF);
    rd_chk("R2 control set", 1, 12'h000, 32'd1);
    do_wr(1, 12'h000, 32'h0000_0000);
    rd_chk("R2 control clear", 0, 12'h000, 32'd0);

    // R3: set/clear views
    for (int k = 0; k < 3; k++) begin
      do_wr(0, sb[k] + 12'h4, a_pat);
      rd_chk("R3 set view after set", 0, sb[k] + 12'h4, a_pat);
      rd_chk("R3 clear view after set", 0, cb[k] + 12'h4, a_pat);
      do_wr(0, sb[k] + 12'h4, 32'd0);
      rd_chk("R3 zero to set view", 0, sb[k] + 12'h4, a_pat);
      do_wr(0, cb[k] + 12'h4, 32'd0);
      rd_chk("R3 zero to clear view", 0, sb[k] + 12'h4, a_pat);
      do_wr(0, cb[k] + 12'h4, 32'h0000_FFFF);
      rd_chk("R3 partial clear", 0, sb[k] + 12'h4, a_pat & 32'hFFFF_0000);
      do_wr(0, cb[k] + 12'h4, 32'hFFFF_FFFF);
      rd_chk("R3 full clear", 0, cb[k] + 12'h4, 32'd0);
    end

    // R5: banking of low IDs
    do_wr(0, 12'h100, 32'h0000_1234);
    do_wr(1, 12'h100, 32'h8000_0001);
    rd_chk("R5 enable bank cpu0", 0, 12'h100, 32'h0000_1234);
    rd_chk("R5 enable bank cpu1", 1, 12'h100, 32'h8000_0001);
    do_wr(1, 12'h104, 32'h0000_00F0);
    rd_chk("R5 shared enable seen by cpu0", 0, 12'h104, 32'h0000_00F0);
    do_wr(0, 12'h180, 32'hFFFF_FFFF);
    rd_chk("R5 clear only cpu0 bank", 1, 12'h100, 32'h8000_0001);

    // R4: group register
    do_wr(0, 12'h084, 32'hDEAD_BEEF);
    rd_chk("R4 shared group", 1, 12'h084, 32'hDEAD_BEEF);
    do_wr(1, 12'h080, 32'h0000_0005);
    rd_chk("R4 group cpu0 bank", 0, 12'h080, 32'd0);
    rd_chk("R4 group cpu1 bank", 1, 12'h080, 32'h0000_0005);

    // R6: priority sweep
    for (int c = 0; c < NUM_CPU; c++)
      for (int p = 0; p < NUM_IRQ / 4; p++)
        do_wr(c, 12'(12'h400 + p * 4), pval(c, p));
    for (int c = 0; c < NUM_CPU; c++)
      for (int p = 0; p < NUM_IRQ / 4; p++)
        rd_chk("R6 priority", c, 12'(12'h400 + p * 4),
               (p < 8) ? pval(c, p) : pval(NUM_CPU - 1, p));

    // R7: targets
    for (int c = 0; c < NUM_CPU; c++)
      for (int p = 0; p < NUM_IRQ / 4; p++)
        do_wr(c, 12'(12'h800 + p * 4), (p < 8) ? 32'hFFFF_FFFF : tval(c, p));
    for (int c = 0; c < NUM_CPU; c++)
      for (int p = 0; p < NUM_IRQ / 4; p++)
        rd_chk("R7 target", c, 12'(12'h800 + p * 4),
               (p < 8) ? {4{8'(1 << c)}} : tval(NUM_CPU - 1, p));

    // R8: trigger fields
    do_wr(0, 12'hC00, 32'hFFFF_FFFF);
    rd_chk("R8 edge bits only", 0, 12'hC00, 32'hAAAA_AAAA);
    rd_chk("R8 banked trigger cpu1", 1, 12'hC00, 32'd0);
    do_wr(1, 12'hC04, 32'h5555_5555);
    rd_chk("R8 low bit ignored", 1, 12'hC04, 32'd0);
    do_wr(1, 12'hC04, 32'h0000_000A);
    rd_chk("R8 two edge fields", 1, 12'hC04, 32'h0000_000A);
    do_wr(0, 12'hC08, 32'h0000_0002);
    rd_chk("R8 shared trigger", 1, 12'hC08, 32'h0000_0002);
    for (int c = 0; c < NUM_CPU; c++)
      for (int t = 0; t < 4; t++)
        do_wr(c, 12'(12'hC00 + t * 4), 32'd0);
    rd_chk("R8 trigger cleared", 0, 12'hC00, 32'd0);

    // R12: out of range
    do_wr(0, 12'h440, 32'hFFFF_FFFF);
    rd_chk("R12 priority past end", 0, 12'h440, 32'd0);
    do_wr(0, 12'h108, 32'hFFFF_FFFF);
    rd_chk("R12 enable past end", 0, 12'h108, 32'd0);
    do_wr(0, 12'hC10, 32'hFFFF_FFFF);
    rd_chk("R12 trigger past end", 0, 12'hC10, 32'd0);
    do_wr(0, 12'h840, 32'hFFFF_FFFF);
    rd_chk("R12 target past end", 0, 12'h840, 32'd0);
    rd_chk("R12 no alias into priority", 0, 12'h400, pval(0, 0));

    // R11: SGI source bytes
    do_wr(0, 12'hF20, 32'h0302_0100);
    rd_chk("R11 set view", 0, 12'hF20, 32'h0302_0100);
    rd_chk("R11 clear view", 0, 12'hF10, 32'h0302_0100);
    rd_chk("R11 per cpu", 1, 12'hF20, 32'd0);
    do_wr(0, 12'hF10, 32'h0101_0101);
    rd_chk("R11 clear bits", 0, 12'hF20, 32'h0202_0000);
    do_wr(0, 12'hF20, 32'd0);
    rd_chk("R11 zero set no effect", 0, 12'hF20, 32'h0202_0000);
    do_wr(1, 12'hF2C, 32'h0000_0080);
    rd_chk("R11 cpu1 word3", 1, 12'hF1C, 32'h0000_0080);

    // R13: read data holds
    rd_chk("R13 prime read", 0, 12'h004, 32'h0000_0021);
    do_wr(0, 12'h104, 32'h0000_0001);
    @(negedge clk);
    check("R13 hold over write and idle", acc_rdata, 32'h0000_0021);

    // R9 / R10: line mapping, level mode
    for (int c = 0; c < NUM_CPU; c++) begin
      do_wr(c, 12'h280, 32'hFFFF_FFFF);
      do_wr(c, 12'h284, 32'hFFFF_FFFF);
    end
    for (int i = 0; i < SLOTS; i++) begin
      @(negedge clk) irq_lines = SLOTS'(1) << i;
      rd_chk("R9 shared word", 0, 12'h204, (i < 32) ? (32'd1 << i) : 32'd0);
      rd_chk("R9 cpu0 private", 0, 12'h200,
             (i >= 32 && i < 64) ? (32'd1 << (i - 32)) : 32'd0);
      rd_chk("R9 cpu1 private", 1, 12'h200,
             (i >= 64) ? (32'd1 << (i - 64)) : 32'd0);
    end
    @(negedge clk) irq_lines = '0;
    rd_chk("R10 level drops", 0, 12'h204, 32'd0);
    rd_chk("R10 level drops private", 1, 12'h200, 32'd0);

    // R10: edge mode on ID 33 (input index 1)
    do_wr(0, 12'hC08, 32'h0000_0008);
    @(negedge clk) irq_lines[1] = 1'b1;
    rd_chk("R10 edge latches", 0, 12'h204, 32'h0000_0002);
    @(negedge clk) irq_lines[1] = 1'b0;
    rd_chk("R10 edge stays after line low", 0, 12'h204, 32'h0000_0002);
    do_wr(0, 12'h284, 32'h0000_0002);
    rd_chk("R10 edge cleared", 0, 12'h204, 32'd0);
    @(negedge clk) irq_lines[1] = 1'b1;
    rd_chk("R10 second edge", 0, 12'h204, 32'h0000_0002);
    do_wr(0, 12'h284, 32'h0000_0002);
    rd_chk("R10 held line no re-trigger", 0, 12'h204, 32'd0);
    @(negedge clk) irq_lines = '0;
    irq_lines[2] = 1'b1;
    do_wr(0, 12'h284, 32'h0000_0004);
    rd_chk("R10 level survives clear", 0, 12'h204, 32'h0000_0004);
    @(negedge clk) irq_lines = '0;
    rd_chk("R10 level gone", 0, 12'h204, 32'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule